// File: doc/BRIEF.md
# Link Receive Phit Guard

This block sits between the deserializer of a serial link and the router core. Each valid phit leaves the block on the next clock edge, before the packet's CRC is known. Cut-through forwarding therefore adds no store-and-forward delay on a hop. The block keeps a running CRC and a body-phit count for the packet in flight. It judges the packet when its end-of-packet (tail) phit arrives, or when the packet grows past a programmable length limit.

A tail whose CRC does not match leaves the block with its status rewritten and its CRC replaced by the value actually received. Downstream logic therefore sees a clean CRC and a clear error verdict. A packet that runs too long is cut short, and a synthetic tail is emitted in place of the phit that broke the limit. On either error the block enters recovery. It stays silent on the output until a clear pulse arrives, and in the same cycle it raises a one-cycle sideband strobe for a later recovery controller.

Top module: `rx_phit_guard`

## Requirements
- R1: A valid phit whose type field (bits 23:22) is not 2'b11 and that does not break the length limit appears unchanged on `outPhit`, with `outValid` high, exactly one clock after it was presented.
- R2: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is fed MSB first with all 24 bits of every forwarded phit of the packet, and the tail phit itself is excluded. A tail phit (type 2'b11) holds its status in bits 21:20 (2'b00 healthy, 2'b01 link error, 2'b10 soft error) and its CRC in bits 15:0. When that CRC matches, the tail is forwarded unchanged and `errCrc` stays low.
- R3: When a tail's CRC does not match and its status is not soft error, the forwarded tail carries status 2'b01 and the computed CRC in bits 15:0, with the other bits unchanged. `errCrc` pulses high in the same cycle.
- R4: When a tail with status 2'b10 fails the CRC check, it keeps status 2'b10 but still gets the computed CRC, and `errCrc` pulses.
- R5: `cfgMaxLen` bounds a packet's total phit count, tail included. A non-tail phit that would become phit number `cfgMaxLen` is not forwarded. In its place the block emits {2'b11, 2'b01, 4'h0, CRC of the forwarded phits} and pulses `errClip`.
- R6: A CRC error or a clip sets `inRecovery` in the same cycle as the error strobe. While `inRecovery` is high, every input phit is dropped and `outValid` stays low.
- R7: A `cfgClear` pulse during recovery drops the phit of that cycle and lowers `inRecovery` on the next edge. The next packet then starts with a fresh CRC and count.
- R8: A packet of exactly `cfgMaxLen` phits, such as a 19-phit packet of 6 header, 12 data and 1 tail phits with a limit of 19, passes whole and does not pulse `errClip`.
- R9: After reset, `outValid`, `errCrc`, `errClip` and `inRecovery` are low.
- R10: Cycles with `inValid` low produce no output and do not change the CRC or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Phit from the deserializer is valid |
| inPhit | input | 24 | Received phit; type in bits 23:22 |
| cfgMaxLen | input | LEN_W | Maximum packet length in phits, tail included |
| cfgClear | input | 1 | Pulse that ends recovery mode |
| outValid | output | 1 | Phit toward the router core is valid |
| outPhit | output | 24 | Forwarded, rewritten or synthetic phit |
| errCrc | output | 1 | One-cycle strobe: tail failed its CRC check |
| errClip | output | 1 | One-cycle strobe: packet was clipped |
| inRecovery | output | 1 | Recovery mode; input is being dropped |

## Verification
On every cycle the assertions check several properties: one-cycle forwarding of accepted phits, silence while in recovery, error strobes that coincide with a tail phit of the right status and with recovery entry, and exit from recovery after a clear. Only the bench's scenarios can show the data values. These include the computed CRC written into a rewritten or synthetic tail, soft-error status kept on a CRC mismatch, and the exact phit at which clipping starts. They also include acceptance of a packet exactly at the limit, idle cycles that leave the CRC untouched, and a fresh packet start after recovery.

// File: rtl/rx_phit_guard_pkg.sv
`timescale 1ns/1ps
package rx_phit_guard_pkg;
  localparam int PHIT_W = 24;
  localparam int CRC_W  = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  localparam logic [1:0] TYPE_TAIL = 2'b11;
  localparam logic [1:0] ST_OK     = 2'b00;
  localparam logic [1:0] ST_LINK   = 2'b01;
  localparam logic [1:0] ST_SOFT   = 2'b10;

  // Strobes from control to datapath.
  typedef struct packed {
    logic fwd;
    logic tail;
    logic clip;
    logic restart;
  } ctlStrobe_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c,
                                               input logic [PHIT_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int i = PHIT_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ d[i];
      r = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/rx_phit_guard_dp.sv
`timescale 1ns/1ps
module rx_phit_guard_dp
  import rx_phit_guard_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHIT_W-1:0] inPhit,
  input  logic [LEN_W-1:0]  cfgMaxLen,
  input  ctlStrobe_t        ctl,
  output logic              crcMatch,
  output logic              atLimit,
  output logic              outValid,
  output logic [PHIT_W-1:0] outPhit,
  output logic              errCrc,
  output logic              errClip
);
  logic [CRC_W-1:0]  crcAcc;
  logic [LEN_W-1:0]  bodyCnt;
  logic [PHIT_W-1:0] tailPhit;
  logic [PHIT_W-1:0] clipPhit;
  logic [1:0]        inStatus;

  assign crcMatch = (crcAcc == inPhit[CRC_W-1:0]);
  assign atLimit  = ({1'b0, bodyCnt} + (LEN_W+1)'(1)) >= {1'b0, cfgMaxLen};
  assign inStatus = inPhit[21:20];

  always_comb begin
    tailPhit = inPhit;
    if (!crcMatch) begin
      tailPhit[21:20]      = (inStatus == ST_SOFT) ? ST_SOFT : ST_LINK;
      tailPhit[CRC_W-1:0]  = crcAcc;
    end
    clipPhit = {TYPE_TAIL, ST_LINK, 4'h0, crcAcc};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcAcc   <= CRC_INIT;
      bodyCnt  <= '0;
      outValid <= 1'b0;
      outPhit  <= '0;
      errCrc   <= 1'b0;
      errClip  <= 1'b0;
    end else begin
      outValid <= ctl.fwd | ctl.tail | ctl.clip;
      errCrc   <= ctl.tail & ~crcMatch;
      errClip  <= ctl.clip;
      if (ctl.fwd) begin
        outPhit <= inPhit;
        crcAcc  <= crcStep(crcAcc, inPhit);
        bodyCnt <= bodyCnt + LEN_W'(1);
      end else begin
        if (ctl.tail) outPhit <= tailPhit;
        if (ctl.clip) outPhit <= clipPhit;
        if (ctl.tail | ctl.clip | ctl.restart) begin
          crcAcc  <= CRC_INIT;
          bodyCnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rx_phit_guard_ctl.sv
`timescale 1ns/1ps
module rx_phit_guard_ctl
  import rx_phit_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inType,
  input  logic       crcMatch,
  input  logic       atLimit,
  input  logic       cfgClear,
  output ctlStrobe_t ctl,
  output logic       inRecovery
);
  logic recovery;
  logic enterRec;

  always_comb begin
    ctl      = '0;
    enterRec = 1'b0;
    if (!recovery && inValid) begin
      if (inType == TYPE_TAIL) begin
        ctl.tail = 1'b1;
        enterRec = ~crcMatch;
      end else if (atLimit) begin
        ctl.clip = 1'b1;
        enterRec = 1'b1;
      end else begin
        ctl.fwd = 1'b1;
      end
    end
    if (recovery && cfgClear) ctl.restart = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         recovery <= 1'b0;
    else if (enterRec) recovery <= 1'b1;
    else if (cfgClear) recovery <= 1'b0;
  end

  assign inRecovery = recovery;
endmodule

// File: rtl/rx_phit_guard.sv
`timescale 1ns/1ps
module rx_phit_guard
  import rx_phit_guard_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [23:0]       inPhit,
  input  logic [LEN_W-1:0]  cfgMaxLen,
  input  logic              cfgClear,
  output logic              outValid,
  output logic [23:0]       outPhit,
  output logic              errCrc,
  output logic              errClip,
  output logic              inRecovery
);
  ctlStrobe_t ctl;
  logic crcMatch;
  logic atLimit;

  rx_phit_guard_ctl u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inType(inPhit[23:22]),
    .crcMatch(crcMatch), .atLimit(atLimit), .cfgClear(cfgClear),
    .ctl(ctl), .inRecovery(inRecovery)
  );

  rx_phit_guard_dp #(.LEN_W(LEN_W), .CRC_INIT(CRC_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .inPhit(inPhit), .cfgMaxLen(cfgMaxLen),
    .ctl(ctl), .crcMatch(crcMatch), .atLimit(atLimit),
    .outValid(outValid), .outPhit(outPhit), .errCrc(errCrc), .errClip(errClip)
  );
endmodule

// File: rtl/rx_phit_guard_chk.sv
`timescale 1ns/1ps
module rx_phit_guard_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [23:0] inPhit,
  input logic        cfgClear,
  input logic        outValid,
  input logic [23:0] outPhit,
  input logic        errCrc,
  input logic        errClip,
  input logic        inRecovery
);
  p_accept_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inRecovery) |=> outValid);

  p_crc_tail_marked_r3: assert property (@(posedge clk) disable iff (!rstN)
    errCrc |-> (outValid && outPhit[23:22] == 2'b11 && outPhit[21:20] != 2'b00));

  p_clip_tail_r5: assert property (@(posedge clk) disable iff (!rstN)
    errClip |-> (outValid && outPhit[23:22] == 2'b11 && outPhit[21:20] == 2'b01));

  p_error_enters_recovery_r6: assert property (@(posedge clk) disable iff (!rstN)
    (errCrc || errClip) |-> inRecovery);

  p_recovery_silent_r6: assert property (@(posedge clk) disable iff (!rstN)
    inRecovery |=> !outValid);

  p_clear_exits_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inRecovery && cfgClear) |=> !inRecovery);

  p_single_error_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(errCrc && errClip));
endmodule

bind rx_phit_guard rx_phit_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inPhit(inPhit),
  .cfgClear(cfgClear), .outValid(outValid), .outPhit(outPhit),
  .errCrc(errCrc), .errClip(errClip), .inRecovery(inRecovery)
);

// File: tb/rx_phit_guard_bench.sv
`timescale 1ns/1ps
module rx_phit_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] inPhit = '0;
  logic [7:0]  cfgMaxLen = 8'd64;
  logic        cfgClear = 1'b0;
  logic        outValid;
  logic [23:0] outPhit;
  logic        errCrc;
  logic        errClip;
  logic        inRecovery;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_phit_guard u_rx_phit_guard (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPhit(inPhit),
    .cfgMaxLen(cfgMaxLen), .cfgClear(cfgClear), .outValid(outValid),
    .outPhit(outPhit), .errCrc(errCrc), .errClip(errClip), .inRecovery(inRecovery)
  );

  function automatic logic [15:0] refCrc(input logic [15:0] c, input logic [23:0] d);
    logic [15:0] r = c;
    for (int b = 23; b >= 0; b--) begin
      if (r[15] ^ d[b]) r = {r[14:0], 1'b0} ^ 16'h1021;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [23:0] mkPhit(input int idx, input int seed);
    logic [1:0] t = (idx < 6) ? 2'b01 : 2'b10;
    return {t, 22'(seed * 1237 + idx * 977 + 5)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Present one input, let one edge pass, return with outputs settled.
  task automatic drive(input logic v, input logic [23:0] p);
    inValid = v;
    inPhit  = p;
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  task automatic sendBody(input int n, input int seed, output logic [15:0] crc);
    crc = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      logic [23:0] p = mkPhit(i, seed);
      drive(1'b1, p);
      check(outValid && outPhit == p, "R1", "forwarded body phit", {7'd0, outValid, outPhit}, {8'h01, p});
      crc = refCrc(crc, p);
    end
  endtask

  task automatic pulseClear();
    cfgClear = 1'b1;
    drive(1'b1, mkPhit(7, 99));
    cfgClear = 1'b0;
    check(!outValid, "R7", "phit in clear cycle dropped", {31'd0, outValid}, 32'd0);
    check(!inRecovery, "R7", "recovery left after clear", {31'd0, inRecovery}, 32'd0);
  endtask

  task automatic tReset();
    check(!outValid && !errCrc && !errClip && !inRecovery, "R9", "reset outputs",
          {28'd0, outValid, errCrc, errClip, inRecovery}, 32'd0);
  endtask

  task automatic tGood(input int nBody, input int seed, input logic [1:0] st, input string req);
    logic [15:0] crc;
    logic [23:0] t;
    sendBody(nBody, seed, crc);
    t = {2'b11, st, 4'h0, crc};
    drive(1'b1, t);
    check(outValid && outPhit == t, req, "good tail unchanged", {8'd0, outPhit}, {8'd0, t});
    check(!errCrc && !errClip && !inRecovery, req, "no error on good tail",
          {29'd0, errCrc, errClip, inRecovery}, 32'd0);
  endtask

  task automatic tBadCrc();
    logic [15:0] crc;
    sendBody(5, 3, crc);
    drive(1'b1, {2'b11, 2'b00, 4'h0, crc ^ 16'h00F0});
    check(outValid && outPhit == {2'b11, 2'b01, 4'h0, crc}, "R3", "rewritten tail",
          {8'd0, outPhit}, {8'd0, 2'b11, 2'b01, 4'h0, crc});
    check(errCrc && !errClip, "R3", "errCrc strobe", {30'd0, errCrc, errClip}, 32'd2);
    check(inRecovery, "R6", "recovery after CRC error", {31'd0, inRecovery}, 32'd1);
    drive(1'b1, mkPhit(0, 4));
    check(!errCrc, "R3", "errCrc one cycle", {31'd0, errCrc}, 32'd0);
    for (int i = 1; i < 4; i++) begin
      drive(1'b1, mkPhit(i, 4));
      check(!outValid, "R6", "phit dropped in recovery", {31'd0, outValid}, 32'd0);
    end
    pulseClear();
    tGood(4, 5, 2'b00, "R7");
  endtask

  task automatic tSoft();
    logic [15:0] crc;
    tGood(3, 8, 2'b10, "R2");
    sendBody(7, 9, crc);
    drive(1'b1, {2'b11, 2'b10, 4'h0, ~crc});
    check(outValid && outPhit == {2'b11, 2'b10, 4'h0, crc}, "R4", "soft status kept, CRC fixed",
          {8'd0, outPhit}, {8'd0, 2'b11, 2'b10, 4'h0, crc});
    check(errCrc && inRecovery, "R4", "errCrc on soft tail", {30'd0, errCrc, inRecovery}, 32'd3);
    pulseClear();
  endtask

  task automatic tClip();
    logic [15:0] crc;
    cfgMaxLen = 8'd18;
    sendBody(17, 11, crc);
    drive(1'b1, mkPhit(17, 11));
    check(outValid && outPhit == {2'b11, 2'b01, 4'h0, crc}, "R5", "synthetic tail",
          {8'd0, outPhit}, {8'd0, 2'b11, 2'b01, 4'h0, crc});
    check(errClip && !errCrc && inRecovery, "R5", "errClip strobe and recovery",
          {29'd0, errClip, errCrc, inRecovery}, 32'd5);
    drive(1'b1, {2'b11, 2'b00, 4'h0, 16'h1234});
    check(!outValid, "R6", "original tail dropped after clip", {31'd0, outValid}, 32'd0);
    pulseClear();
    // Limit of 1: a lone tail fits, any body phit is clipped at once.
    cfgMaxLen = 8'd1;
    tGood(0, 0, 2'b00, "R5");
    drive(1'b1, mkPhit(0, 12));
    check(outValid && outPhit == {2'b11, 2'b01, 4'h0, 16'hFFFF} && errClip, "R5",
          "clip of first phit", {7'd0, errClip, outPhit}, {8'h01, 2'b11, 2'b01, 4'h0, 16'hFFFF});
    pulseClear();
  endtask

  task automatic tExact();
    logic [15:0] crc;
    logic [23:0] t;
    cfgMaxLen = 8'd19;
    sendBody(18, 21, crc);
    t = {2'b11, 2'b00, 4'h0, crc};
    drive(1'b1, t);
    check(outValid && outPhit == t && !errClip && !inRecovery, "R8", "19-phit packet at limit",
          {6'd0, errClip, inRecovery, outPhit}, {8'd0, t});
    cfgMaxLen = 8'd64;
  endtask

  task automatic tIdle();
    logic [15:0] crc = 16'hFFFF;
    logic [23:0] t;
    for (int i = 0; i < 4; i++) begin
      logic [23:0] p = mkPhit(i, 30);
      drive(1'b1, p);
      check(outValid && outPhit == p, "R1", "body phit between gaps", {8'd0, outPhit}, {8'd0, p});
      crc = refCrc(crc, p);
      drive(1'b0, 24'hABCDEF);
      check(!outValid, "R10", "no output on idle cycle", {31'd0, outValid}, 32'd0);
    end
    t = {2'b11, 2'b00, 4'h0, crc};
    drive(1'b1, t);
    check(outValid && outPhit == t && !errCrc, "R10", "idle cycles kept out of CRC",
          {7'd0, errCrc, outPhit}, {8'd0, t});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    rstN = 1'b1;
    @(posedge clk);
    #1;
    tReset();
    tGood(6, 1, 2'b00, "R2");
    tGood(18, 2, 2'b00, "R2");
    tBadCrc();
    tSoft();
    tClip();
    tExact();
    tIdle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule